// File: doc/BRIEF.md
# Virtual Interrupt Register Access Decoder

This block decides what happens when a coprocessor read instruction targets the register that reports the highest-priority pending group-1 interrupt identifier. It checks the instruction's encoding fields. It then applies a strictly ordered chain of checks that depends on the current exception level. The access ends in exactly one outcome: undefined instruction, trap to the hypervisor, trap to the secure monitor, return of the virtual pending identifier, or return of the physical pending identifier.

The block is purely combinational. The requesting pipeline stage drives the encoding, the level, the controls and both identifier views. In the same cycle it takes back the one-hot outcome, a trap class code and a 32-bit read word. The read word is masked to the implemented identifier width. Choosing which interrupt is pending happens upstream of this block.

The level is encoded as 0 = user, 1 = kernel, 2 = hypervisor and 3 = monitor.

Top module: `virq_read_decoder`

## Requirements
- R1: The access is taken up only when `rdReq` is 1 and the encoding is coproc 15, opc1 0, CRn 12, CRm 12, opc2 2. In every other case all five result outputs are 0, `trapClass` is 0 and `readData` is 0.
- R2: For a matching request, exactly one of `resUndef`, `resTrapHyp`, `resTrapMon`, `resVirt` and `resPhys` is 1.
- R3: At level 0 (user), a matching read is always undefined.
- R4: At level 1 (kernel), the first check is `hypEnabled` together with `hypCp12Trap`. When both are 1, the access traps to the hypervisor. This check comes before every other check.
- R5: At level 1, the next check is `sreKernel`. When it is 0, the access is undefined. After that, if `hypEnabled` and `hypTrapAllG1` are both 1, the access traps to the hypervisor.
- R6: At level 1, the next check is `hypEnabled` with `hypIrqRoute`. When both are 1, the virtual identifier is returned.
- R7: At level 1, the next check is `monExists` with `monIrqRoute`. When both are 1, the access traps to the monitor. This trap is skipped when `monIs32` and `inMonMode` are both 1. In all remaining cases the physical identifier is returned.
- R8: At level 2 (hypervisor), `sreHyp` = 0 gives undefined. Otherwise `monExists` with `monIrqRoute` traps to the monitor, and `monIs32` does not change this. Otherwise the physical identifier is returned.
- R9: At level 3 (monitor), `sreMon` = 0 gives undefined. Otherwise the physical identifier is returned.
- R10: When a value is returned, `readData[23:0]` carries the selected identifier and `readData[31:24]` is 0. When `idWide` = 0, `readData[23:16]` is also 0. When no value is returned, `readData` is 0.
- R11: `trapClass` is 0x03 when either trap result is selected, and 0 otherwise.
- R12: The special identifier 1023, which signals that no pending interrupt is observable, passes to `readData` unchanged in both views and at both widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rdReq | input | 1 | A coprocessor read instruction is issued |
| insCoproc | input | 4 | Coprocessor number field |
| insOpc1 | input | 3 | First opcode field |
| insCrn | input | 4 | Primary register field |
| insCrm | input | 4 | Secondary register field |
| insOpc2 | input | 3 | Second opcode field |
| curLevel | input | 2 | Current exception level (0 user, 1 kernel, 2 hyp, 3 monitor) |
| hypEnabled | input | 1 | Hypervisor level exists and is enabled |
| monExists | input | 1 | Secure monitor level exists |
| monIs32 | input | 1 | Monitor runs 32-bit state |
| inMonMode | input | 1 | Processor is currently in monitor mode |
| hypCp12Trap | input | 1 | Hypervisor trap for coprocessor-12 accesses |
| sreKernel | input | 1 | System-register interface enable at kernel level |
| hypTrapAllG1 | input | 1 | Hypervisor traps all group-1 accesses |
| hypIrqRoute | input | 1 | Hypervisor routes IRQs to itself (virtual view) |
| monIrqRoute | input | 1 | Monitor routes IRQs to itself |
| sreHyp | input | 1 | System-register interface enable at hypervisor level |
| sreMon | input | 1 | System-register interface enable at monitor level |
| virtPendId | input | 24 | Virtual highest pending identifier |
| physPendId | input | 24 | Physical highest pending identifier |
| idWide | input | 1 | 1: 24-bit identifiers implemented, 0: 16-bit |
| resUndef | output | 1 | Outcome: undefined instruction |
| resTrapHyp | output | 1 | Outcome: trap to hypervisor |
| resTrapMon | output | 1 | Outcome: trap to monitor |
| resVirt | output | 1 | Outcome: virtual identifier returned |
| resPhys | output | 1 | Outcome: physical identifier returned |
| trapClass | output | 6 | Trap class code, 0x03 on a trap |
| readData | output | 32 | Read data word |

## Verification
The assertions are immediate checks. They evaluate only when every input and output is a known value, so they take for granted that the requester never presents X or Z on the encoding, level or control pins. The stimulus drives every pin to a defined value from time zero and changes inputs only between sampling points. The identifier inputs are treated as opaque values. The stimulus uses distinct patterns for the virtual and physical views so that a wrong view selection or a wrong width mask shows up at the read port.

// File: rtl/virq_rd_pkg.sv
package virq_rd_pkg;
  localparam int LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } level_e;

  // one-hot access outcome
  typedef struct packed {
    logic undef;
    logic trapHyp;
    logic trapMon;
    logic retVirt;
    logic retPhys;
  } result_t;

  // strobes from control to datapath
  typedef struct packed {
    logic pickVirt;
    logic pickPhys;
    logic raiseTrap;
  } dpStrobe_t;
endpackage

// File: rtl/virq_rd_match.sv
module virq_rd_match #(
  parameter int COP_W = 4,
  parameter int OP1_W = 3,
  parameter int CRN_W = 4,
  parameter int CRM_W = 4,
  parameter int OP2_W = 3,
  parameter int COP_VAL = 15,
  parameter int OP1_VAL = 0,
  parameter int CRN_VAL = 12,
  parameter int CRM_VAL = 12,
  parameter int OP2_VAL = 2
) (
  input  logic             rdReq,
  input  logic [COP_W-1:0] insCoproc,
  input  logic [OP1_W-1:0] insOpc1,
  input  logic [CRN_W-1:0] insCrn,
  input  logic [CRM_W-1:0] insCrm,
  input  logic [OP2_W-1:0] insOpc2,
  output logic             hit
);
  localparam int NFIELD = 5;
  logic [NFIELD-1:0] fieldOk;

  always_comb begin
    fieldOk[0] = (insCoproc == COP_W'(COP_VAL));
    fieldOk[1] = (insOpc1   == OP1_W'(OP1_VAL));
    fieldOk[2] = (insCrn    == CRN_W'(CRN_VAL));
    fieldOk[3] = (insCrm    == CRM_W'(CRM_VAL));
    fieldOk[4] = (insOpc2   == OP2_W'(OP2_VAL));
    hit = rdReq & (&fieldOk);
  end
endmodule

// File: rtl/virq_rd_ctl.sv
module virq_rd_ctl
  import virq_rd_pkg::*;
(
  input  logic             hit,
  input  logic [LVL_W-1:0] curLevel,
  input  logic             hypEnabled,
  input  logic             monExists,
  input  logic             monIs32,
  input  logic             inMonMode,
  input  logic             hypCp12Trap,
  input  logic             sreKernel,
  input  logic             hypTrapAllG1,
  input  logic             hypIrqRoute,
  input  logic             monIrqRoute,
  input  logic             sreHyp,
  input  logic             sreMon,
  output result_t          res,
  output dpStrobe_t        strobe
);
  logic monRouteKernel;
  logic monRouteHyp;

  always_comb begin
    // a 32-bit monitor does not re-trap its own mode from kernel level
    monRouteKernel = monExists & monIrqRoute & ~(monIs32 & inMonMode);
    monRouteHyp    = monExists & monIrqRoute;
  end

  always_comb begin
    res = '0;
    if (hit) begin
      unique case (level_e'(curLevel))
        LVL_USER: res.undef = 1'b1;
        LVL_KERNEL: begin
          if (hypEnabled && hypCp12Trap)       res.trapHyp = 1'b1;
          else if (!sreKernel)                 res.undef   = 1'b1;
          else if (hypEnabled && hypTrapAllG1) res.trapHyp = 1'b1;
          else if (hypEnabled && hypIrqRoute)  res.retVirt = 1'b1;
          else if (monRouteKernel)             res.trapMon = 1'b1;
          else                                 res.retPhys = 1'b1;
        end
        LVL_HYP: begin
          if (!sreHyp)          res.undef   = 1'b1;
          else if (monRouteHyp) res.trapMon = 1'b1;
          else                  res.retPhys = 1'b1;
        end
        LVL_MON: begin
          if (!sreMon) res.undef   = 1'b1;
          else         res.retPhys = 1'b1;
        end
        default: res = '0;
      endcase
    end
  end

  always_comb begin
    strobe.pickVirt  = res.retVirt;
    strobe.pickPhys  = res.retPhys;
    strobe.raiseTrap = res.trapHyp | res.trapMon;
  end
endmodule

// File: rtl/virq_rd_dp.sv
module virq_rd_dp
  import virq_rd_pkg::*;
#(
  parameter int ID_W      = 24,
  parameter int NARROW_W  = 16,
  parameter int DATA_W    = 32,
  parameter int CLASS_W   = 6,
  parameter int TRAP_CODE = 3
) (
  input  dpStrobe_t          strobe,
  input  logic [ID_W-1:0]    virtPendId,
  input  logic [ID_W-1:0]    physPendId,
  input  logic               idWide,
  output logic [DATA_W-1:0]  readData,
  output logic [CLASS_W-1:0] trapClass
);
  logic [ID_W-1:0] keepMask;
  logic [ID_W-1:0] idSel;

  for (genvar g = 0; g < ID_W; g++) begin : gMask
    if (g < NARROW_W) begin : gLow
      assign keepMask[g] = 1'b1;
    end else begin : gHigh
      assign keepMask[g] = idWide;
    end
  end

  always_comb begin
    if (strobe.pickVirt)      idSel = virtPendId;
    else if (strobe.pickPhys) idSel = physPendId;
    else                      idSel = '0;
    readData = '0;
    readData[ID_W-1:0] = idSel & keepMask;
    trapClass = strobe.raiseTrap ? CLASS_W'(TRAP_CODE) : '0;
  end
endmodule

// File: rtl/virq_read_decoder.sv
module virq_read_decoder
  import virq_rd_pkg::*;
#(
  parameter int ID_W     = 24,
  parameter int NARROW_W = 16,
  parameter int DATA_W   = 32,
  parameter int CLASS_W  = 6
) (
  input  logic               rdReq,
  input  logic [3:0]         insCoproc,
  input  logic [2:0]         insOpc1,
  input  logic [3:0]         insCrn,
  input  logic [3:0]         insCrm,
  input  logic [2:0]         insOpc2,
  input  logic [LVL_W-1:0]   curLevel,
  input  logic               hypEnabled,
  input  logic               monExists,
  input  logic               monIs32,
  input  logic               inMonMode,
  input  logic               hypCp12Trap,
  input  logic               sreKernel,
  input  logic               hypTrapAllG1,
  input  logic               hypIrqRoute,
  input  logic               monIrqRoute,
  input  logic               sreHyp,
  input  logic               sreMon,
  input  logic [ID_W-1:0]    virtPendId,
  input  logic [ID_W-1:0]    physPendId,
  input  logic               idWide,
  output logic               resUndef,
  output logic               resTrapHyp,
  output logic               resTrapMon,
  output logic               resVirt,
  output logic               resPhys,
  output logic [CLASS_W-1:0] trapClass,
  output logic [DATA_W-1:0]  readData
);
  logic      hit;
  result_t   res;
  dpStrobe_t strobe;

  virq_rd_match uMatch (
    .rdReq(rdReq), .insCoproc(insCoproc), .insOpc1(insOpc1),
    .insCrn(insCrn), .insCrm(insCrm), .insOpc2(insOpc2), .hit(hit)
  );

  virq_rd_ctl uCtl (
    .hit(hit), .curLevel(curLevel), .hypEnabled(hypEnabled),
    .monExists(monExists), .monIs32(monIs32), .inMonMode(inMonMode),
    .hypCp12Trap(hypCp12Trap), .sreKernel(sreKernel),
    .hypTrapAllG1(hypTrapAllG1), .hypIrqRoute(hypIrqRoute),
    .monIrqRoute(monIrqRoute), .sreHyp(sreHyp), .sreMon(sreMon),
    .res(res), .strobe(strobe)
  );

  virq_rd_dp #(
    .ID_W(ID_W), .NARROW_W(NARROW_W), .DATA_W(DATA_W), .CLASS_W(CLASS_W)
  ) uDp (
    .strobe(strobe), .virtPendId(virtPendId), .physPendId(physPendId),
    .idWide(idWide), .readData(readData), .trapClass(trapClass)
  );

  always_comb begin
    resUndef   = res.undef;
    resTrapHyp = res.trapHyp;
    resTrapMon = res.trapMon;
    resVirt    = res.retVirt;
    resPhys    = res.retPhys;
  end
endmodule

// File: rtl/virq_read_decoder_chk.sv
module virq_read_decoder_chk #(
  parameter int ID_W     = 24,
  parameter int NARROW_W = 16,
  parameter int DATA_W   = 32,
  parameter int CLASS_W  = 6
) (
  input logic               rdReq,
  input logic [3:0]         insCoproc,
  input logic [2:0]         insOpc1,
  input logic [3:0]         insCrn,
  input logic [3:0]         insCrm,
  input logic [2:0]         insOpc2,
  input logic [1:0]         curLevel,
  input logic               idWide,
  input logic               resUndef,
  input logic               resTrapHyp,
  input logic               resTrapMon,
  input logic               resVirt,
  input logic               resPhys,
  input logic [CLASS_W-1:0] trapClass,
  input logic [DATA_W-1:0]  readData
);
  logic       encOk;
  logic [4:0] resVec;
  logic       anyTrap;

  always_comb begin
    encOk   = rdReq && insCoproc == 4'd15 && insOpc1 == 3'd0 &&
              insCrn == 4'd12 && insCrm == 4'd12 && insOpc2 == 3'd2;
    resVec  = {resUndef, resTrapHyp, resTrapMon, resVirt, resPhys};
    anyTrap = resTrapHyp | resTrapMon;
  end

  always_comb begin
    if (!$isunknown({rdReq, insCoproc, insOpc1, insCrn, insCrm, insOpc2,
                     curLevel, idWide, resVec, trapClass, readData})) begin
      // R1
      quiet_nomatch_chk: assert (encOk || (resVec == '0 && readData == '0));
      // R2
      single_result_chk: assert ($countones(resVec) == (encOk ? 1 : 0));
      // R3
      user_undef_chk: assert (!(encOk && curLevel == 2'd0) || resUndef);
      // R8
      hyp_no_selftrap_chk: assert (!(curLevel == 2'd2 && resTrapHyp));
      // R9
      mon_no_trap_chk: assert (!(curLevel == 2'd3 && anyTrap));
      // R10
      top_byte_zero_chk: assert (readData[DATA_W-1:ID_W] == '0);
      // R10
      narrow_mask_chk: assert (idWide || readData[ID_W-1:NARROW_W] == '0);
      // R10
      no_value_zero_chk: assert ((resVirt || resPhys) || readData == '0);
      // R11
      trap_class_chk: assert (trapClass == (anyTrap ? CLASS_W'(3) : '0));
    end
  end
endmodule

bind virq_read_decoder virq_read_decoder_chk #(
  .ID_W(ID_W), .NARROW_W(NARROW_W), .DATA_W(DATA_W), .CLASS_W(CLASS_W)
) chk (
  .rdReq(rdReq), .insCoproc(insCoproc), .insOpc1(insOpc1), .insCrn(insCrn),
  .insCrm(insCrm), .insOpc2(insOpc2), .curLevel(curLevel), .idWide(idWide),
  .resUndef(resUndef), .resTrapHyp(resTrapHyp), .resTrapMon(resTrapMon),
  .resVirt(resVirt), .resPhys(resPhys), .trapClass(trapClass),
  .readData(readData)
);

// File: tb/virq_read_decoder_test.sv
`timescale 1ns/1ps
module virq_read_decoder_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  int checkCount = 0;
  int failCount  = 0;

  logic        rdReq;
  logic [3:0]  insCoproc, insCrn, insCrm;
  logic [2:0]  insOpc1, insOpc2;
  logic [1:0]  curLevel;
  logic        hypEnabled, monExists, monIs32, inMonMode, hypCp12Trap;
  logic        sreKernel, hypTrapAllG1, hypIrqRoute, monIrqRoute, sreHyp, sreMon;
  logic [23:0] virtPendId, physPendId;
  logic        idWide;
  logic        resUndef, resTrapHyp, resTrapMon, resVirt, resPhys;
  logic [5:0]  trapClass;
  logic [31:0] readData;

  virq_read_decoder uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outVec();
    return {resUndef, resTrapHyp, resTrapMon, resVirt, resPhys};
  endfunction

  task automatic setGood();
    rdReq = 1; insCoproc = 4'd15; insOpc1 = 3'd0; insCrn = 4'd12;
    insCrm = 4'd12; insOpc2 = 3'd2;
  endtask

  // control bits: {hypEnabled,monExists,monIs32,inMonMode,hypCp12Trap,
  //                sreKernel,hypTrapAllG1,hypIrqRoute,monIrqRoute,sreHyp,sreMon}
  task automatic setCtl(input logic [10:0] c);
    {hypEnabled, monExists, monIs32, inMonMode, hypCp12Trap, sreKernel,
     hypTrapAllG1, hypIrqRoute, monIrqRoute, sreHyp, sreMon} = c;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // independent reference: returns {undef,trapHyp,trapMon,virt,phys}
  function automatic logic [4:0] refModel(input logic [1:0] lvl, input logic [10:0] c,
                                          output string tag);
    logic he, me, m32, inm, cp, sk, ta, hr, mr, sh, sm;
    {he, me, m32, inm, cp, sk, ta, hr, mr, sh, sm} = c;
    case (lvl)
      2'd0: begin tag = "R3"; return 5'b10000; end
      2'd1: begin
        if (he && cp) begin tag = "R4"; return 5'b01000; end
        if (!sk) begin tag = "R5"; return 5'b10000; end
        if (he && ta) begin tag = "R5"; return 5'b01000; end
        if (he && hr) begin tag = "R6"; return 5'b00010; end
        if (me && mr && !(m32 && inm)) begin tag = "R7"; return 5'b00100; end
        tag = "R7"; return 5'b00001;
      end
      2'd2: begin
        tag = "R8";
        if (!sh) return 5'b10000;
        if (me && mr) return 5'b00100;
        return 5'b00001;
      end
      default: begin
        tag = "R9";
        if (!sm) return 5'b10000;
        return 5'b00001;
      end
    endcase
  endfunction

  task automatic testReset();
    settle();
    check("R1 reset idle results", {27'd0, outVec()}, 32'd0);
    check("R1 reset idle data", readData, 32'd0);
    check("R11 reset idle class", {26'd0, trapClass}, 32'd0);
  endtask

  task automatic testEncoding();
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #2;
      setGood(); curLevel = 2'd3; setCtl(11'h7FF);
      case (k)
        0: insCoproc = 4'd14;
        1: insOpc1 = 3'd1;
        2: insCrn = 4'd11;
        3: insCrm = 4'd13;
        4: insOpc2 = 3'd0;
        default: rdReq = 0;
      endcase
      settle();
      check("R1 mismatch results", {27'd0, outVec()}, 32'd0);
      check("R1 mismatch data", readData, 32'd0);
      check("R11 mismatch class", {26'd0, trapClass}, 32'd0);
    end
  endtask

  task automatic testSweep();
    for (int lvl = 0; lvl < 4; lvl++) begin
      for (int c = 0; c < 2048; c++) begin
        logic [4:0] exp;
        string tag;
        logic [23:0] expId;
        logic [31:0] expData;
        @(posedge clk); #2;
        setGood(); curLevel = lvl[1:0]; setCtl(c[10:0]);
        virtPendId = 24'h5A0000 | 24'(c * 3 + lvl);
        physPendId = 24'hA30000 | 24'(c * 7 + 1);
        idWide = c[0] ^ lvl[0];
        exp = refModel(lvl[1:0], c[10:0], tag);
        expId = exp[1] ? virtPendId : exp[0] ? physPendId : 24'd0;
        if (!idWide) expId[23:16] = 8'd0;
        expData = {8'd0, expId};
        settle();
        check({tag, " R2 result"}, {27'd0, outVec()}, {27'd0, exp});
        check({tag, " R11 class"}, {26'd0, trapClass},
              (exp[3] || exp[2]) ? 32'd3 : 32'd0);
        check({tag, " R10 data"}, readData, expData);
      end
    end
  endtask

  task automatic testWidth();
    @(posedge clk); #2;
    setGood(); curLevel = 2'd3; setCtl(11'h7FF);
    physPendId = 24'hFEDCBA; idWide = 1;
    settle();
    check("R10 wide phys data", readData, 32'h00FEDCBA);
    @(posedge clk); #2; idWide = 0;
    settle();
    check("R10 narrow phys data", readData, 32'h0000DCBA);
  endtask

  task automatic testSpecial();
    for (int w = 0; w < 2; w++) begin
      @(posedge clk); #2;
      setGood(); curLevel = 2'd1; idWide = w[0];
      setCtl(11'b10000101000); // hyp enabled, kernel enable, hyp IRQ route
      virtPendId = 24'd1023; physPendId = 24'd5;
      settle();
      check("R12 special id virtual view", readData, 32'd1023);
      @(posedge clk); #2;
      setCtl(11'b00000100000); // kernel enable only
      virtPendId = 24'd7; physPendId = 24'd1023;
      settle();
      check("R12 special id physical view", readData, 32'd1023);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    rdReq = 0; insCoproc = 0; insOpc1 = 0; insCrn = 0; insCrm = 0; insOpc2 = 0;
    curLevel = 0; setCtl('0); virtPendId = 0; physPendId = 0; idWide = 1;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testReset();
    testEncoding();
    testSweep();
    testWidth();
    testSpecial();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end
endmodule